// File: doc/BRIEF.md
# Desaturation Protection Channel Controller

This block is the digital controller for one switch of a half-bridge gate driver. It takes a registered on/off command and the digitised output of a desaturation comparator. It drives three output-stage controls: a source enable, a sink enable and a soft-shutdown pull-down enable. Each control is active high: 1 means that stage is driving and 0 means that stage is released to high impedance. A fourth control, `boost_en`, gates a second source stage that helps only at the start of each turn-on.

The comparator input is evaluated only while the switch is commanded on. It is ignored during a blanking window after every turn-on, and it must stay high for a minimum run of samples to count. A qualified event starts a soft-shutdown sequence of fixed length, during which source and sink are both released and only the pull-down acts. After the sequence the channel holds the switch off until the command has been low. All durations are parameters in cycles of the system clock. The default values assume 50 MHz: 150 cycles of blanking (3 µs), 25 cycles of filter (0.5 µs), 463 cycles of soft shutdown (about 9.25 µs) and 10 cycles of boost (200 ns).

The controller is a Moore machine with five states. OFF is the idle state with the sink driven. BLANK is the first part of the on-time, with desaturation masked. ON is the rest of the on-time, with desaturation armed. SSD is the soft shutdown. REARM holds the switch off after a shutdown. The transitions are:
- OFF→BLANK when the command is high.
- BLANK→ON when the blanking count expires.
- BLANK→OFF and ON→OFF when the command is low.
- ON→SSD on a filtered desaturation hit.
- SSD→REARM when the shutdown count expires.
- REARM→OFF once the command is low.

Top module: `desat_channel_ctrl`

## Requirements
- R1: After reset the outputs are snk_en=1 and every other output 0.
- R2: While off (OFF or REARM) only snk_en is 1, and a high desat_in has no effect on any output.
- R3: All outputs are registered from state, so a change of cmd_on shows on the outputs one clock later. While on (BLANK or ON), src_en=1 with snk_en=0 and ssd_en=0.
- R4: boost_en is 1 for the first BOOST_CYC cycles of each on-time (never outside src_en=1) and 0 for the remainder.
- R5: desat_in is ignored for the first BLANK_CYC on-cycles. If desat_in is held high from turn-on, the first shutdown cycle is on-cycle BLANK_CYC+FILT_CYC+1.
- R6: Shutdown starts only after FILT_CYC consecutive high samples of desat_in taken in state ON. The first shutdown cycle follows the FILT_CYC-th sample. Shorter runs never start a shutdown, and any low sample restarts the count.
- R7: During shutdown ssd_en=1, ssd_active=1, src_en=0, snk_en=0 and boost_en=0, for exactly SSD_CYC cycles.
- R8: desat_evt is 1 only in the first shutdown cycle, and ssd_done is 1 only in the last.
- R9: Once a shutdown has started, cmd_on has no effect until the shutdown ends.
- R10: After a shutdown the outputs return to the off pattern and stay there while cmd_on is high. A new on-time starts only after cmd_on has been sampled low and then high.
- R11: cmd_on low during BLANK or ON gives the off pattern one cycle later and discards the filter count. The next turn-on runs the full blanking window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Registered on/off command, 1 = on |
| desat_in | input | 1 | Digitised desaturation comparator, 1 = over threshold |
| src_en | output | 1 | Main source stage enable (1 = drive high) |
| snk_en | output | 1 | Sink stage enable (1 = drive low) |
| ssd_en | output | 1 | Soft-shutdown pull-down enable |
| boost_en | output | 1 | Second source stage enable, one-shot at turn-on |
| desat_evt | output | 1 | Pulse in the first shutdown cycle |
| ssd_active | output | 1 | High for the whole shutdown |
| ssd_done | output | 1 | Pulse in the last shutdown cycle |

## Verification
The bench sweeps the length of a desaturation pulse around the filter width. A filter that is off by one would shut down on a run one sample short, or need one sample too many. A desaturation signal held high from the moment of turn-on pins down the blanking window: a design that let the filter count during blanking would shut down early. The bench also drops the command at every offset inside blanking, so a design that kept its blanking or filter state across an aborted turn-on would be caught. The command is also dropped during a shutdown, and kept high after one, which exposes a sequence that stops early or a channel that turns itself back on without a fresh command.

// File: rtl/desat_pkg.sv
package desat_pkg;

    typedef enum logic [2:0] {
        CH_OFF   = 3'd0,
        CH_BLANK = 3'd1,
        CH_ON    = 3'd2,
        CH_SSD   = 3'd3,
        CH_REARM = 3'd4
    } ch_state_e;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/desat_glitch_filter.sv
module desat_glitch_filter #(
    parameter int FILT_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic raw,
    output logic hit
);
    localparam int CW = desat_pkg::cnt_width(FILT_CYC);
    localparam logic [CW-1:0] RUN_MAX = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_q;
    logic          sample_hi;

    assign sample_hi = enable && raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!sample_hi) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit = sample_hi && (run_q == RUN_MAX);

endmodule

// File: rtl/desat_window_timer.sv
module desat_window_timer #(
    parameter int LEN = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = desat_pkg::cnt_width(LEN);
    localparam logic [CW-1:0] CNT_END = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    assign last = run && (cnt_q == CNT_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/boost_oneshot.sv
module boost_oneshot #(
    parameter int BOOST_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic hold,
    output logic active
);
    generate
        if (BOOST_CYC == 0) begin : g_none
            assign active = 1'b0;
        end else begin : g_count
            localparam int CW = desat_pkg::cnt_width(BOOST_CYC + 1);
            localparam logic [CW-1:0] LOAD = CW'(BOOST_CYC);
            logic [CW-1:0] left_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    left_q <= '0;
                end else if (fire) begin
                    left_q <= LOAD;
                end else if (!hold) begin
                    left_q <= '0;
                end else if (left_q != '0) begin
                    left_q <= left_q - 1'b1;
                end
            end

            assign active = (left_q != '0);
        end
    endgenerate

endmodule

// File: rtl/desat_channel_ctrl.sv
module desat_channel_ctrl #(
    parameter int BLANK_CYC = 150,
    parameter int FILT_CYC  = 25,
    parameter int SSD_CYC   = 463,
    parameter int BOOST_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_on,
    input  logic desat_in,
    output logic src_en,
    output logic snk_en,
    output logic ssd_en,
    output logic boost_en,
    output logic desat_evt,
    output logic ssd_active,
    output logic ssd_done
);
    import desat_pkg::*;

    ch_state_e state_q, state_d;
    logic      first_q;
    logic      blank_last, ssd_last, filt_hit, boost_live;
    logic      in_blank, in_on, in_ssd, drive_on, turn_on;

    assign in_blank = (state_q == CH_BLANK);
    assign in_on    = (state_q == CH_ON);
    assign in_ssd   = (state_q == CH_SSD);
    assign drive_on = in_blank || in_on;
    assign turn_on  = (state_q == CH_OFF) && cmd_on;

    desat_window_timer #(.LEN(BLANK_CYC)) blank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_blank),
        .last  (blank_last)
    );

    desat_window_timer #(.LEN(SSD_CYC)) ssd_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_ssd),
        .last  (ssd_last)
    );

    desat_glitch_filter #(.FILT_CYC(FILT_CYC)) filt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (in_on && cmd_on),
        .raw    (desat_in),
        .hit    (filt_hit)
    );

    boost_oneshot #(.BOOST_CYC(BOOST_CYC)) boost_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (turn_on),
        .hold   (drive_on),
        .active (boost_live)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (cmd_on) state_d = CH_BLANK;
            end
            CH_BLANK: begin
                if (!cmd_on)         state_d = CH_OFF;
                else if (blank_last) state_d = CH_ON;
            end
            CH_ON: begin
                if (!cmd_on)       state_d = CH_OFF;
                else if (filt_hit) state_d = CH_SSD;
            end
            CH_SSD: begin
                if (ssd_last) state_d = CH_REARM;
            end
            CH_REARM: begin
                if (!cmd_on) state_d = CH_OFF;
            end
            default: state_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            first_q <= (state_d == CH_SSD) && (state_q != CH_SSD);
        end
    end

    // outputs
    always_comb begin
        src_en     = 1'b0;
        snk_en     = 1'b0;
        ssd_en     = 1'b0;
        boost_en   = 1'b0;
        desat_evt  = 1'b0;
        ssd_active = 1'b0;
        ssd_done   = 1'b0;
        unique case (state_q)
            CH_OFF, CH_REARM: begin
                snk_en = 1'b1;
            end
            CH_BLANK, CH_ON: begin
                src_en   = 1'b1;
                boost_en = boost_live;
            end
            CH_SSD: begin
                ssd_en     = 1'b1;
                ssd_active = 1'b1;
                desat_evt  = first_q;
                ssd_done   = ssd_last;
            end
            default: begin
                snk_en = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/desat_channel_chk.sv
module desat_channel_chk #(
    parameter int SSD_CYC   = 463,
    parameter int BOOST_CYC = 10
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_on,
    input logic desat_in,
    input logic src_en,
    input logic snk_en,
    input logic ssd_en,
    input logic boost_en,
    input logic desat_evt,
    input logic ssd_active,
    input logic ssd_done
);
    localparam int LW = $clog2(SSD_CYC + 2);
    logic [LW-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          len_q <= '0;
        else if (ssd_active) len_q <= len_q + 1'b1;
        else                 len_q <= '0;
    end

    // R3
    one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({src_en, snk_en, ssd_en}) == 1);

    // R4
    boost_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boost_en |-> src_en);

    // R4
    boost_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (BOOST_CYC > 0) && $rose(src_en) |-> boost_en);

    // R2
    ssd_from_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssd_active) |-> $past(src_en) && $past(cmd_on));

    // R8
    evt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desat_evt |-> $rose(ssd_active));

    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssd_done |=> !ssd_active);

    // R9
    ssd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssd_active && !ssd_done |=> ssd_active);

    // R7
    ssd_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssd_active |-> len_q < LW'(SSD_CYC));

    // R7
    ssd_len_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ssd_active) |-> len_q == LW'(SSD_CYC));

endmodule

bind desat_channel_ctrl desat_channel_chk #(
    .SSD_CYC   (SSD_CYC),
    .BOOST_CYC (BOOST_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_on     (cmd_on),
    .desat_in   (desat_in),
    .src_en     (src_en),
    .snk_en     (snk_en),
    .ssd_en     (ssd_en),
    .boost_en   (boost_en),
    .desat_evt  (desat_evt),
    .ssd_active (ssd_active),
    .ssd_done   (ssd_done)
);

// File: tb/desat_channel_ctrl_tb.sv
`timescale 1ns/1ps
module desat_channel_ctrl_tb_top;
    localparam int B = 6;
    localparam int F = 3;
    localparam int S = 10;
    localparam int P = 2;

    localparam logic [6:0] O_OFF = 7'b0100000;
    localparam logic [6:0] O_ON  = 7'b1000000;
    localparam logic [6:0] O_ONB = 7'b1001000;
    localparam logic [6:0] O_S1  = 7'b0010110;
    localparam logic [6:0] O_SM  = 7'b0010010;
    localparam logic [6:0] O_SL  = 7'b0010011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_on = 1'b0;
    logic desat_in = 1'b0;
    logic src_en, snk_en, ssd_en, boost_en, desat_evt, ssd_active, ssd_done;
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    desat_channel_ctrl #(
        .BLANK_CYC (B),
        .FILT_CYC  (F),
        .SSD_CYC   (S),
        .BOOST_CYC (P)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_on     (cmd_on),
        .desat_in   (desat_in),
        .src_en     (src_en),
        .snk_en     (snk_en),
        .ssd_en     (ssd_en),
        .boost_en   (boost_en),
        .desat_evt  (desat_evt),
        .ssd_active (ssd_active),
        .ssd_done   (ssd_done)
    );

    function automatic logic [6:0] on_exp(input int k);
        return (k <= P) ? O_ONB : O_ON;
    endfunction

    function automatic logic [6:0] ssd_exp(input int j);
        if (j == 1) return O_S1;
        if (j == S) return O_SL;
        return O_SM;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [6:0] exp);
        logic [6:0] obs;
        obs = {src_en, snk_en, ssd_en, boost_en, desat_evt, ssd_active, ssd_done};
        n_run++;
        if (obs !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, obs, exp);
        end
    endtask

    task automatic idle();
        cmd_on = 1'b0;
        desat_in = 1'b0;
        repeat (S + 4) step();
    endtask

    task automatic reach_on();
        cmd_on = 1'b1;
        repeat (B + 1) step();
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        chk("R1 reset", O_OFF);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", O_OFF);

        // R2: desat while off is ignored
        desat_in = 1'b1;
        for (int k = 0; k < 8; k++) begin
            step();
            chk("R2 off desat", O_OFF);
        end
        desat_in = 1'b0;

        // R3 R4: clean on-time, then off one cycle later
        cmd_on = 1'b1;
        for (int k = 1; k <= B + 4; k++) begin
            step();
            chk("R3 R4 on", on_exp(k));
        end
        cmd_on = 1'b0;
        step();
        chk("R3 off latency", O_OFF);
        idle();

        // R5: desat high from turn-on; R7 R8 sequence; R10 rearm
        desat_in = 1'b1;
        cmd_on = 1'b1;
        for (int k = 1; k <= B + F + 1; k++) begin
            step();
            chk("R5 blank", (k <= B + F) ? on_exp(k) : O_S1);
        end
        desat_in = 1'b0;
        for (int j = 2; j <= S; j++) begin
            step();
            chk("R7 R8 ssd", ssd_exp(j));
        end
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R10 hold off", O_OFF);
        end
        cmd_on = 1'b0;
        step();
        chk("R10 cmd low", O_OFF);
        cmd_on = 1'b1;
        step();
        chk("R10 rearm on", O_ONB);
        idle();

        // R6: pulse width sweep in ON
        for (int w = 1; w <= F + 1; w++) begin
            reach_on();
            chk("R6 reached on", O_ON);
            desat_in = 1'b1;
            for (int k = 1; k <= w + F + 2; k++) begin
                step();
                if (k == w) desat_in = 1'b0;
                if (w >= F && k >= F)
                    chk("R6 filter", (k == F) ? O_S1 : O_SM);
                else
                    chk("R6 filter", O_ON);
            end
            idle();
            chk("R6 back off", O_OFF);
        end

        // R6: broken runs never qualify
        reach_on();
        for (int r = 0; r < 3; r++) begin
            desat_in = 1'b1;
            repeat (F - 1) step();
            desat_in = 1'b0;
            step();
            chk("R6 broken run", O_ON);
        end
        idle();

        // R9: command drop during shutdown
        reach_on();
        desat_in = 1'b1;
        repeat (F) step();
        chk("R9 ssd start", O_S1);
        desat_in = 1'b0;
        cmd_on = 1'b0;
        for (int j = 2; j <= S; j++) begin
            step();
            chk("R9 ssd ignores cmd", ssd_exp(j));
        end
        step();
        chk("R9 after ssd", O_OFF);
        step();
        chk("R9 off", O_OFF);
        cmd_on = 1'b1;
        step();
        chk("R9 new on", O_ONB);
        idle();

        // R11: abort at each blanking offset, then full re-blank
        for (int d = 1; d <= B; d++) begin
            desat_in = 1'b1;
            cmd_on = 1'b1;
            repeat (d) step();
            cmd_on = 1'b0;
            step();
            chk("R11 abort blank", O_OFF);
            cmd_on = 1'b1;
            for (int k = 1; k <= B + F + 1; k++) begin
                step();
                if (k == B + F || k == B + F + 1)
                    chk("R11 reblank", (k <= B + F) ? on_exp(k) : O_S1);
            end
            idle();
        end

        // R11: abort in ON with a partial filter run
        reach_on();
        desat_in = 1'b1;
        repeat (F - 1) step();
        cmd_on = 1'b0;
        step();
        chk("R11 abort on", O_OFF);
        desat_in = 1'b0;
        reach_on();
        desat_in = 1'b1;
        repeat (F - 1) step();
        chk("R11 filter restarted", O_ON);
        step();
        chk("R11 filter full", O_S1);
        idle();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule